// File: doc/BRIEF.md
# Enable-Gated Line Decoder with 16-Way Expansion

This block turns a binary address into one active-low select line. Its core is a 3-bit line decoder with three enable inputs of mixed polarity: one active-high and two active-low. The decoder drives a line only when all three enables are in their active state. If any enable is inactive, every output rests high. A data stream fed into one of the active-low enables therefore shows up on the addressed line while the other lines stay high. This lets the same gate work as a 1-to-8 demultiplexer.

The top level chains two copies of that decoder into a 4-bit, 16-line decoder. Both copies receive address bits 2..0. Address bit 3 steers the enables: when it is clear, the low copy (lines 0..7) is enabled, and when it is set, the high copy (lines 8..15) is enabled. The top keeps the same three mixed-polarity enables, so the whole 16-line decoder can itself be gated, chained or used as a 1-to-16 demultiplexer. The logic is purely combinational.

Top module: `dec16_expand`

## Requirements
- R1: When en_hi=1, en_a_n=0 and en_b_n=0, exactly one bit of y_n is 0, and its index equals the binary value of addr (addr 5 drives y_n[5] low).
- R2: When en_hi=0, all 16 bits of y_n are 1, regardless of addr and the other enables.
- R3: When en_a_n=1, all 16 bits of y_n are 1, regardless of addr and the other enables.
- R4: When en_b_n=1, all 16 bits of y_n are 1, regardless of addr and the other enables.
- R5: With en_hi=1 and en_b_n=0, y_n[addr] equals the value driven on en_a_n bit for bit, and every other bit of y_n stays 1 (1-to-16 demultiplexing).
- R6: When enabled, an address with bit 3 clear leaves y_n[15:8] all 1, and an address with bit 3 set leaves y_n[7:0] all 1.
- R7: y_n follows changes on addr and the enables within the same time step, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 4 | Binary line address; bit 3 selects the upper or lower bank |
| en_hi | input | 1 | Active-high enable |
| en_a_n | input | 1 | Active-low enable; also the data input for demultiplexing |
| en_b_n | input | 1 | Active-low enable |
| y_n | output | 16 | Active-low decoded lines |

## Verification
The bench drives all 16 addresses under all eight enable combinations. The single fully enabled combination checks the one-hot index and the bank split. Each of the seven disabled combinations isolates which enable, alone or together with others, must force every line high. Each output is checked twice: one time unit after the inputs change, which shows the outputs respond without storage, and again at the next clock edge. A serial bit pattern is then driven on the low-true enable while the address is held. This shows that the addressed line copies the data and that no other line moves.

// File: rtl/dec16_expand.sv
module line_dec #(
  parameter int AW = 3
) (
  input  logic [AW-1:0]      sel,
  input  logic               g_hi,
  input  logic               g_lo_a_n,
  input  logic               g_lo_b_n,
  output logic [(1<<AW)-1:0] y_n
);
  localparam int N = 1 << AW;
  logic on;
  assign on = g_hi & ~g_lo_a_n & ~g_lo_b_n;
  for (genvar i = 0; i < N; i++) begin : g_line
    assign y_n[i] = ~(on && (sel == AW'(i)));
  end
endmodule

module dec16_expand (
  input  logic [3:0]  addr,
  input  logic        en_hi,
  input  logic        en_a_n,
  input  logic        en_b_n,
  output logic [15:0] y_n
);
  line_dec #(.AW(3)) u_lo (
    .sel(addr[2:0]), .g_hi(en_hi), .g_lo_a_n(en_a_n | addr[3]),
    .g_lo_b_n(en_b_n), .y_n(y_n[7:0])
  );
  line_dec #(.AW(3)) u_hi (
    .sel(addr[2:0]), .g_hi(en_hi & addr[3]), .g_lo_a_n(en_a_n),
    .g_lo_b_n(en_b_n), .y_n(y_n[15:8])
  );
endmodule

// File: rtl/dec16_expand_chk.sv
module dec16_expand_chk (
  input logic [3:0]  addr,
  input logic        en_hi,
  input logic        en_a_n,
  input logic        en_b_n,
  input logic [15:0] y_n
);
  logic act;
  assign act = en_hi & ~en_a_n & ~en_b_n;
  always_comb begin
    if (act) begin
      AST_ONE_LINE: assert ($countones(~y_n) == 1) else $error("one line");  // R1
      AST_LINE_IDX: assert (y_n[addr] == 1'b0) else $error("index");        // R1
      if (addr[3]) begin
        AST_LOW_BANK_IDLE: assert (&y_n[7:0]) else $error("low bank");      // R6
      end else begin
        AST_HIGH_BANK_IDLE: assert (&y_n[15:8]) else $error("high bank");   // R6
      end
    end
    if (!en_hi) begin
      AST_OFF_HI: assert (&y_n) else $error("en_hi off");                   // R2
    end
    if (en_a_n) begin
      AST_OFF_A: assert (&y_n) else $error("en_a_n off");                   // R3
    end
    if (en_b_n) begin
      AST_OFF_B: assert (&y_n) else $error("en_b_n off");                   // R4
    end
  end
endmodule

bind dec16_expand dec16_expand_chk u_chk (
  .addr(addr), .en_hi(en_hi), .en_a_n(en_a_n), .en_b_n(en_b_n), .y_n(y_n)
);

// File: tb/tb_dec16_expand.sv
module tb_dec16_expand;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0;
  logic [3:0] addr = '0;
  logic en_hi = 1'b0, en_a_n = 1'b1, en_b_n = 1'b1;
  logic [15:0] y_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec16_expand dut (.addr(addr), .en_hi(en_hi), .en_a_n(en_a_n), .en_b_n(en_b_n), .y_n(y_n));

  function automatic logic [15:0] model(int a, bit h, bit an, bit bn);
    logic [15:0] v = 16'hFFFF;
    if (h && !an && !bn) v[a] = 1'b0;
    return v;
  endfunction

  function automatic string tag_of(bit h, bit an, bit bn, int a);
    if (!h) return "R2";
    if (an) return "R3";
    if (bn) return "R4";
    return (a >= 8) ? "R1,R6(high)" : "R1,R6(low)";
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R2 idle state", y_n, 16'hFFFF);
    for (int a = 0; a < 16; a++) begin
      for (int e = 0; e < 8; e++) begin
        @(negedge clk);
        addr = 4'(a); en_hi = e[0]; en_a_n = e[1]; en_b_n = e[2];
        #1;
        check("R7 immediate", y_n, model(a, e[0], e[1], e[2]));
        @(posedge clk); #1;
        check(tag_of(e[0], e[1], e[2], a), y_n, model(a, e[0], e[1], e[2]));
      end
    end
    for (int a = 0; a < 16; a += 5) begin
      logic [15:0] pat = 16'hA5C3;
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        addr = 4'(a); en_hi = 1'b1; en_b_n = 1'b0; en_a_n = pat[b];
        @(posedge clk); #1;
        check("R5 demux", y_n, model(a, 1'b1, pat[b], 1'b0));
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule